// File: doc/BRIEF.md
# Block Carry-Skip Adder

This block adds two unsigned N-bit words and a carry-in, and returns the N-bit sum and a carry-out. Addition is modulo 2^N. The width is split into equal ripple groups. Inside a group the carry ripples from bit to bit. Each group also forms the AND of its per-bit propagate signals. When that AND is true, a bypass multiplexer sends the group's carry-in straight to its carry-out. Otherwise the group generates or kills the carry itself, and its ripple result is used.

With every middle group on its bypass path, the longest carry path is short. It starts at bit 0, ripples to the top of the first group, skips each middle group, and ripples through the last group. The block has no registers. Its outputs follow its inputs in the same cycle, so it can sit between two pipeline registers of a datapath. The default build is 16 bits wide with four groups of 4 bits (bits 0-3, 4-7, 8-11 and 12-15). Any group size that divides the width evenly is accepted. A group size that does not divide the width stops elaboration.

The house style calls for an enumerated state machine. This block has no state, so there are no states or transitions to name.

Top module: `csa_adder`

## Requirements
- R1: For any operands `a`, `b` and carry-in `cin`, {`cout`,`sum`} equals a + b + cin, computed with WIDTH+1 bits.
- R2: The sum wraps modulo 2^WIDTH. All ones plus zero with `cin`=1 gives `sum`=0 and `cout`=1. All ones plus all ones with `cin`=1 gives all ones and `cout`=1.
- R3: When every bit propagates (`b` = ~`a`), each group takes its bypass path. Then `cout` equals `cin` and every `sum` bit equals the inverse of `cin`.
- R4: The worst-case chain gives the correct result. In this chain bit 0 generates and all higher bits propagate (`a`=all ones, `b`=1, `cin`=0), which gives `sum`=0 and `cout`=1. The same holds when only the top group propagates and the carry comes from a lower group.
- R5: Each bit is classified as exactly one of generate (a&b), propagate (a^b) or kill (~a&~b). A bit that kills absorbs any incoming carry. So `a`=`b`=0 with `cin`=1 gives `sum`=1 and `cout`=0, and a killing top bit forces `cout`=0.
- R6: The block is combinational. A new input is reflected on `sum` and `cout` within the same cycle, with no clock involved.
- R7: A non-default configuration (WIDTH=12, GROUP=3) meets R1 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench uses several classes of input, and each class tests a different part of the carry path:

- Random operand pairs check the arithmetic against a reference sum. They mix generate, propagate and kill bits in every group.
- Complementary operand pairs force every group onto its bypass. They check that the skip multiplexer forwards the carry correctly, and they give a result that differs from a broken bypass.
- The worst-case pattern (generate at bit 0, propagate everywhere above) shows whether the carry travels the full skip chain.
- Kill patterns show whether a group stops the carry.
- The same random and complementary patterns are run on a 12-bit instance with 3-bit groups. This shows that the grouping parameter is honoured.

// File: rtl/csa_pkg.sv
package csa_pkg;
    // Classification of one bit position of the operands.
    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } bit_stat_t;
endpackage

// File: rtl/csa_bit_cell.sv
module csa_bit_cell
    import csa_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    output bit_stat_t stat
);
    always_comb begin
        stat.gen  = a_bit & b_bit;
        stat.prop = a_bit ^ b_bit;
        stat.kill = ~a_bit & ~b_bit;
    end
endmodule

// File: rtl/csa_skip_mux.sv
module csa_skip_mux (
    input  logic skip_sel,
    input  logic carry_bypass,
    input  logic carry_ripple,
    output logic carry_out
);
    always_comb begin
        carry_out = skip_sel ? carry_bypass : carry_ripple;
    end
endmodule

// File: rtl/csa_group.sv
module csa_group
    import csa_pkg::*;
#(
    parameter int GROUP = 4
) (
    input  logic                  [GROUP-1:0] a,
    input  logic                  [GROUP-1:0] b,
    input  logic                              cin,
    output logic                  [GROUP-1:0] sum,
    output logic                              cout,
    output logic                              prop_all,
    output bit_stat_t [GROUP-1:0]             bit_status
);
    logic [GROUP:0]   chain;
    logic [GROUP-1:0] prop_vec;

    assign chain[0] = cin;

    for (genvar i = 0; i < GROUP; i++) begin : g_bit
        csa_bit_cell u_cell (
            .a_bit (a[i]),
            .b_bit (b[i]),
            .stat  (bit_status[i])
        );
        assign prop_vec[i]  = bit_status[i].prop;
        assign chain[i+1]   = bit_status[i].gen | (bit_status[i].prop & chain[i]);
        assign sum[i]       = bit_status[i].prop ^ chain[i];
    end

    assign prop_all = &prop_vec;

    csa_skip_mux u_skip (
        .skip_sel     (prop_all),
        .carry_bypass (cin),
        .carry_ripple (chain[GROUP]),
        .carry_out    (cout)
    );
endmodule

// File: rtl/csa_adder.sv
module csa_adder
    import csa_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NGRP = WIDTH / GROUP;

    if ((WIDTH % GROUP) != 0) begin : g_bad_group
        $error("csa_adder: GROUP must divide WIDTH evenly");
    end

    logic [NGRP:0]            grp_carry;
    logic [NGRP-1:0]          grp_prop;
    bit_stat_t [WIDTH-1:0]    bit_status;

    assign grp_carry[0] = cin;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        csa_group #(.GROUP(GROUP)) u_grp (
            .a          (a[k*GROUP +: GROUP]),
            .b          (b[k*GROUP +: GROUP]),
            .cin        (grp_carry[k]),
            .sum        (sum[k*GROUP +: GROUP]),
            .cout       (grp_carry[k+1]),
            .prop_all   (grp_prop[k]),
            .bit_status (bit_status[k*GROUP +: GROUP])
        );
    end

    assign cout = grp_carry[NGRP];
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk
    import csa_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input logic [WIDTH-1:0]         a,
    input logic [WIDTH-1:0]         b,
    input logic                     cin,
    input logic [WIDTH-1:0]         sum,
    input logic                     cout,
    input logic [WIDTH/GROUP:0]     grp_carry,
    input logic [WIDTH/GROUP-1:0]   grp_prop,
    input bit_stat_t [WIDTH-1:0]    bit_status
);
    localparam int NGRP = WIDTH / GROUP;

    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            // R1
            sum_match_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
            // R2
            wrap_chk: assert (!((&a) && (b == '0) && cin) || ((sum == '0) && cout));
            // R3
            word_prop_chk: assert (!(&(a ^ b)) || ((cout == cin) && (sum == {WIDTH{~cin}})));
            for (int k = 0; k < NGRP; k++) begin
                // R3
                bypass_fwd_chk: assert (!grp_prop[k] || (grp_carry[k+1] == grp_carry[k]));
            end
            for (int i = 0; i < WIDTH; i++) begin
                // R5
                onehot_stat_chk: assert ($onehot({bit_status[i].gen, bit_status[i].prop, bit_status[i].kill}));
            end
        end
    end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
    .a          (a),
    .b          (b),
    .cin        (cin),
    .sum        (sum),
    .cout       (cout),
    .grp_carry  (grp_carry),
    .grp_prop   (grp_prop),
    .bit_status (bit_status)
);

// File: tb/csa_adder_test.sv
module csa_adder_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int W3 = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0]  a, b, sum;
    logic          cin, cout;
    logic [W3-1:0] a3, b3, sum3;
    logic          cin3, cout3;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    csa_adder #(.WIDTH(W), .GROUP(4)) uut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    csa_adder #(.WIDTH(W3), .GROUP(3)) uut_g3 (
        .a(a3), .b(b3), .cin(cin3), .sum(sum3), .cout(cout3)
    );

    task automatic check16(input string req, input logic [W:0] exp);
        checks++;
        if ({cout, sum} !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, {cout, sum}, exp);
        end
    endtask

    task automatic apply16(input string req, input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        @(negedge clk);
        a = va; b = vb; cin = vc;
        #1;
        check16(req, {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc});
    endtask

    task automatic apply12(input string req, input logic [W3-1:0] va, input logic [W3-1:0] vb, input logic vc);
        @(negedge clk);
        a3 = va; b3 = vb; cin3 = vc;
        #1;
        checks++;
        if ({cout3, sum3} !== ({1'b0, va} + {1'b0, vb} + {{W3{1'b0}}, vc})) begin
            fails++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, va, vb, vc,
                     {cout3, sum3}, {1'b0, va} + {1'b0, vb} + {{W3{1'b0}}, vc});
        end
    endtask

    // R6: idle inputs give zero, and a change shows up 1 time unit later
    task automatic t_comb;
        check16("R6 idle", 17'h0_0000);
        a = 16'h1234; b = 16'h0001; cin = 1'b1;
        #1;
        check16("R6 same-cycle", 17'h0_1236);
    endtask

    // R1: random operands against reference sum
    task automatic t_random;
        for (int n = 0; n < 300; n++)
            apply16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
    endtask

    // R2: modulo wrap
    task automatic t_wrap;
        apply16("R2 ones+0+1", 16'hFFFF, 16'h0000, 1'b1);
        check16("R2 ones+0+1 fixed", 17'h1_0000);
        apply16("R2 ones+ones+1", 16'hFFFF, 16'hFFFF, 1'b1);
        check16("R2 ones+ones+1 fixed", 17'h1_FFFF);
    endtask

    // R3: every bit propagates, every group bypasses
    task automatic t_all_prop;
        logic [W-1:0] pat [4] = '{16'h0000, 16'hA5C3, 16'h0F0F, 16'hFFFF};
        for (int n = 0; n < 4; n++) begin
            apply16("R3 bypass cin0", pat[n], ~pat[n], 1'b0);
            check16("R3 bypass cin0 fixed", {1'b0, 16'hFFFF});
            apply16("R3 bypass cin1", pat[n], ~pat[n], 1'b1);
            check16("R3 bypass cin1 fixed", {1'b1, 16'h0000});
        end
    endtask

    // R4: worst-case carry chain
    task automatic t_worst;
        apply16("R4 worst", 16'hFFFF, 16'h0001, 1'b0);
        check16("R4 worst fixed", 17'h1_0000);
        // carry made in group 2, group 3 all propagate
        apply16("R4 top bypass", 16'hF800, 16'h0800, 1'b0);
        check16("R4 top bypass fixed", 17'h1_0000);
        // carry made in group 0, groups 1,2 bypass, group 3 ripples partway
        apply16("R4 mid bypass", 16'h0FF8, 16'h0008, 1'b0);
        check16("R4 mid bypass fixed", 17'h0_1000);
    endtask

    // R5: kill absorbs carry
    task automatic t_kill;
        apply16("R5 all kill", 16'h0000, 16'h0000, 1'b1);
        check16("R5 all kill fixed", 17'h0_0001);
        apply16("R5 top kill", 16'h7FFF, 16'h0001, 1'b0);
        check16("R5 top kill fixed", 17'h0_8000);
        apply16("R5 group kill", 16'h00F0, 16'h0010, 1'b1);
        check16("R5 group kill fixed", 17'h0_0101);
    endtask

    // R7: 12-bit, 3-bit groups
    task automatic t_g3;
        for (int n = 0; n < 100; n++)
            apply12("R7 random", 12'($urandom), 12'($urandom), 1'($urandom));
        apply12("R7 bypass", 12'h5A5, 12'hA5A, 1'b1);
        apply12("R7 worst", 12'hFFF, 12'h001, 1'b0);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        a3 = '0; b3 = '0; cin3 = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_comb();
        t_random();
        t_wrap();
        t_all_prop();
        t_worst();
        t_kill();
        t_g3();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule